// File: doc/BRIEF.md
# Dual Byte Queue with Threshold Events

This block holds two independent byte queues of 32 entries each. One queue carries bytes from the host toward a transmit shifter, and the other carries bytes from a receive shifter toward the host. Each side pushes and pops with single-cycle strobes. The block reports, for each queue, a fill count, full and empty status and a sticky overflow flag. It also raises a level-based event per queue from a coded trigger setting.

The receive event stays high while the receive count is at or above its trigger level. The transmit event stays high while the transmit count is at or below its trigger level. These two events let an interrupt controller wake the host to drain the receive queue or to refill the transmit queue. Each queue has its own flush strobe, which empties it in one cycle. Each overflow flag is cleared by its own clear strobe.

Top module: `dual_byte_queue`

## Requirements
- R1: Each queue delivers bytes in push order. The oldest byte is shown on the head output while the queue is non-empty, and the head output reads 0 when the queue is empty. Level, full and empty change in the cycle after the strobe edge.
- R2: `level_word` carries the transmit count in bits 5:0 and the receive count in bits 11:6. Each count ranges from 0 to 32. Full is asserted at 32 and empty is asserted at 0.
- R3: A push while the queue is full is dropped. The stored bytes and the count are unchanged, and the queue's overflow flag is set.
- R4: An overflow flag stays at 1 until its clear strobe is seen. If a dropped push and a clear arrive in the same cycle, the flag ends up at 1.
- R5: A pop while the queue is empty is ignored. The count stays 0 and the head stays 0.
- R6: A flush strobe empties only its own queue in the next cycle. A push or pop on that queue in the flush cycle is discarded, and the overflow flag is not changed by the flush.
- R7: The 3-bit receive trigger code selects the level as follows: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 16 and 4 gives 30. Codes 5, 6 and 7 act as level 1. `rx_event` is 1 while the receive count is at or above the selected level.
- R8: The 2-bit transmit trigger code selects the level as follows: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. `tx_event` is 1 while the transmit count is at or below the selected level.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged and preserve the order. On a full queue, the pop still takes effect but the push is dropped, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Host writes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte for the transmit queue |
| tx_pop | input | 1 | Shifter takes the transmit head |
| tx_head | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Shifter writes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes the receive head |
| rx_head | output | 8 | Oldest receive byte, 0 when empty |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| tx_ovf_clr | input | 1 | Clear the transmit overflow flag |
| rx_ovf_clr | input | 1 | Clear the receive overflow flag |
| rx_trig_code | input | 3 | Receive trigger code |
| tx_trig_code | input | 2 | Transmit trigger code |
| level_word | output | 12 | Receive count in bits 11:6, transmit count in bits 5:0 |
| tx_full | output | 1 | Transmit queue holds 32 bytes |
| tx_empty | output | 1 | Transmit queue holds no byte |
| rx_full | output | 1 | Receive queue holds 32 bytes |
| rx_empty | output | 1 | Receive queue holds no byte |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_event | output | 1 | Transmit count is at or below its trigger level |
| rx_event | output | 1 | Receive count is at or above its trigger level |

## Verification
The assertions assume that every strobe is a clean, synchronous level sampled once per clock. They also assume that the trigger codes are stable in any cycle where their event is compared. A push, pop, flush or clear may arrive in any combination, including a push against a full queue and a pop against an empty one. The stimulus drives all inputs on the falling edge and holds the trigger codes constant while a queue is filled. It deliberately issues collisions such as a flush with a push and a clear with a dropped push, so the priority rules are exercised without violating those assumptions.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

  localparam int unsigned QDEPTH = 32;
  localparam int unsigned QLVL_W = $clog2(QDEPTH + 1);

  typedef logic [QLVL_W-1:0] lvl_t;

  // receive trigger: non-uniform steps, reserved codes fall back to one entry
  function automatic lvl_t rx_trigger(input logic [2:0] code);
    case (code)
      3'd1:    return lvl_t'(4);
      3'd2:    return lvl_t'(8);
      3'd3:    return lvl_t'(16);
      3'd4:    return lvl_t'(30);
      default: return lvl_t'(1);
    endcase
  endfunction

  // transmit trigger: every code is defined
  function automatic lvl_t tx_trigger(input logic [1:0] code);
    case (code)
      2'd1:    return lvl_t'(4);
      2'd2:    return lvl_t'(8);
      2'd3:    return lvl_t'(16);
      default: return lvl_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/dbq_fifo.sv
module dbq_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              ovf
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  cnt;

  // named internal events
  logic push_ok, pop_ok, push_drop;

  assign full      = (cnt == LVL_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_drop = push & full & ~flush;
  assign level     = cnt;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // set outranks clear so a fresh drop is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (push_drop) ovf <= 1'b1;
    else if (ovf_clr)   ovf <= 1'b0;
  end

  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  p_full_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_drop_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop) |=> level == $past(level));
  p_drop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf);
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !push_drop) |=> !ovf);
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && head == '0));
  p_flush_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !ovf_clr) |=> ovf == $past(ovf));
  p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> level == $past(level));

endmodule

// File: rtl/dbq_trigger.sv
module dbq_trigger #(
  parameter int unsigned LVL_W       = 6,
  parameter bit          AT_OR_ABOVE = 1'b1
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             fire
);

  generate
    if (AT_OR_ABOVE) begin : g_above
      assign fire = (level >= thresh);
    end else begin : g_below
      assign fire = (level <= thresh);
    end
  endgenerate

endmodule

// File: rtl/dual_byte_queue.sv
module dual_byte_queue
  import dbq_pkg::*;
#(
  parameter int unsigned DEPTH  = QDEPTH,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_head,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_head,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              tx_ovf_clr,
  input  logic              rx_ovf_clr,
  input  logic [2:0]        rx_trig_code,
  input  logic [1:0]        tx_trig_code,
  output logic [2*$clog2(DEPTH+1)-1:0] level_word,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              tx_ovf,
  output logic              rx_ovf,
  output logic              tx_event,
  output logic              rx_event
);

  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] tx_level, rx_level;
  logic [LVL_W-1:0] tx_thresh, rx_thresh;

  assign tx_thresh  = LVL_W'(tx_trigger(tx_trig_code));
  assign rx_thresh  = LVL_W'(rx_trigger(rx_trig_code));
  assign level_word = {rx_level, tx_level};

  dbq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(tx_wdata),
    .pop(tx_pop), .flush(tx_flush), .ovf_clr(tx_ovf_clr), .head(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty), .ovf(tx_ovf));

  dbq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_wdata),
    .pop(rx_pop), .flush(rx_flush), .ovf_clr(rx_ovf_clr), .head(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty), .ovf(rx_ovf));

  dbq_trigger #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)) u_tx_trig (
    .level(tx_level), .thresh(tx_thresh), .fire(tx_event));

  dbq_trigger #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)) u_rx_trig (
    .level(rx_level), .thresh(rx_thresh), .fire(rx_event));

  // an empty queue is below every transmit level, a full one above every receive level
  p_tx_empty_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_event);
  p_rx_full_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_event);
  p_rx_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_event);

endmodule

// File: tb/dual_byte_queue_tb_top.sv
module dual_byte_queue_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = 0, rx_wdata = 0;
  logic tx_flush = 0, rx_flush = 0, tx_ovf_clr = 0, rx_ovf_clr = 0;
  logic [2:0] rx_trig_code = 0;
  logic [1:0] tx_trig_code = 0;
  logic [7:0] tx_head, rx_head;
  logic [11:0] level_word;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_ovf, rx_ovf, tx_event, rx_event;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dual_byte_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_head(tx_head),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_head(rx_head),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_ovf_clr(tx_ovf_clr), .rx_ovf_clr(rx_ovf_clr),
    .rx_trig_code(rx_trig_code), .tx_trig_code(tx_trig_code),
    .level_word(level_word),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .tx_event(tx_event), .rx_event(rx_event));

  // {count[5:0], rx code[2:0], tx code[1:0], expected rx_event, expected tx_event}
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    {6'd0,  3'd0, 2'd0, 1'b0, 1'b1},
    {6'd1,  3'd0, 2'd0, 1'b1, 1'b1},
    {6'd2,  3'd0, 2'd0, 1'b1, 1'b0},
    {6'd3,  3'd1, 2'd1, 1'b0, 1'b1},
    {6'd4,  3'd1, 2'd1, 1'b1, 1'b1},
    {6'd5,  3'd1, 2'd1, 1'b1, 1'b0},
    {6'd7,  3'd2, 2'd2, 1'b0, 1'b1},
    {6'd8,  3'd2, 2'd2, 1'b1, 1'b1},
    {6'd9,  3'd2, 2'd2, 1'b1, 1'b0},
    {6'd15, 3'd3, 2'd3, 1'b0, 1'b1},
    {6'd16, 3'd3, 2'd3, 1'b1, 1'b1},
    {6'd17, 3'd3, 2'd3, 1'b1, 1'b0},
    {6'd29, 3'd4, 2'd3, 1'b0, 1'b0},
    {6'd30, 3'd4, 2'd3, 1'b1, 1'b0},
    {6'd32, 3'd4, 2'd0, 1'b1, 1'b0},
    {6'd0,  3'd5, 2'd0, 1'b0, 1'b1},
    {6'd1,  3'd6, 2'd0, 1'b1, 1'b1},
    {6'd1,  3'd7, 2'd2, 1'b1, 1'b1},
    {6'd0,  3'd4, 2'd3, 1'b0, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic clear_strobes;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_flush = 0; rx_flush = 0; tx_ovf_clr = 0; rx_ovf_clr = 0;
  endtask

  task automatic push_both(input int n);
    for (int i = 0; i < n; i++) begin
      tx_push = 1; rx_push = 1; tx_wdata = 8'(i); rx_wdata = 8'(8'h80 + i);
      step();
      clear_strobes();
    end
  endtask

  task automatic flush_both;
    tx_flush = 1; rx_flush = 1;
    step();
    clear_strobes();
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    // reset state
    chk(level_word, 0, "R2 reset level word");
    chk({tx_empty, rx_empty, tx_full, rx_full}, 4'b1100, "R2 reset empty/full");
    chk({tx_ovf, rx_ovf}, 0, "R4 reset overflow flags");
    chk({tx_event, rx_event}, 2'b10, "R8 R7 reset events");
    chk({tx_head, rx_head}, 0, "R1 reset heads read zero");
    rst_n = 1;
    step();

    // table walk: levels and trigger decoding
    for (int v = 0; v < NV; v++) begin
      flush_both();
      rx_trig_code = VEC[v][6:4];
      tx_trig_code = VEC[v][3:2];
      push_both(int'(VEC[v][12:7]));
      chk(level_word, {VEC[v][12:7], VEC[v][12:7]}, $sformatf("R2 level word vector %0d", v));
      chk(rx_event, VEC[v][1], $sformatf("R7 rx_event vector %0d", v));
      chk(tx_event, VEC[v][0], $sformatf("R8 tx_event vector %0d", v));
    end
    flush_both();
    rx_trig_code = 0; tx_trig_code = 0;

    // R1 ordering with show-ahead head
    push_both(3);
    chk(tx_head, 8'h00, "R1 tx head first byte");
    chk(rx_head, 8'h80, "R1 rx head first byte");
    for (int i = 0; i < 3; i++) begin
      chk(tx_head, 8'(i), "R1 tx order");
      chk(rx_head, 8'(8'h80 + i), "R1 rx order");
      tx_pop = 1; rx_pop = 1;
      step();
      clear_strobes();
    end
    chk({tx_empty, rx_empty}, 2'b11, "R1 empty after draining");
    chk({tx_head, rx_head}, 0, "R1 empty heads read zero");

    // R5 pop on empty
    tx_pop = 1; rx_pop = 1;
    step();
    clear_strobes();
    chk(level_word, 0, "R5 pop on empty keeps level zero");
    chk({tx_head, rx_head}, 0, "R5 pop on empty keeps head zero");

    // R3 fill transmit queue then overflow
    for (int i = 0; i < 32; i++) begin
      tx_push = 1; tx_wdata = 8'(i);
      step();
      clear_strobes();
    end
    chk(tx_full, 1'b1, "R2 tx full at 32");
    chk(level_word[5:0], 32, "R2 tx level 32");
    chk(tx_ovf, 1'b0, "R3 no overflow before extra push");
    tx_push = 1; tx_wdata = 8'hEE;
    step();
    clear_strobes();
    chk(level_word[5:0], 32, "R3 dropped push keeps level");
    chk(tx_head, 8'h00, "R3 dropped push keeps head");
    chk(tx_ovf, 1'b1, "R3 overflow flag set");
    chk(rx_ovf, 1'b0, "R3 rx flag untouched by tx overflow");

    // R9 push plus pop while full: pop taken, push dropped
    tx_push = 1; tx_wdata = 8'hDD; tx_pop = 1;
    step();
    clear_strobes();
    chk(level_word[5:0], 31, "R9 full push+pop level");
    for (int i = 1; i < 32; i++) begin
      chk(tx_head, 8'(i), "R3 R9 stored bytes unchanged");
      tx_pop = 1;
      step();
      clear_strobes();
    end
    chk(tx_empty, 1'b1, "R3 drained after overflow");
    chk(tx_ovf, 1'b1, "R4 flag sticky through pops");

    // R6 flush does not touch flag
    tx_push = 1; tx_wdata = 8'h44;
    step();
    clear_strobes();
    tx_flush = 1;
    step();
    clear_strobes();
    chk(level_word[5:0], 0, "R6 tx flush empties");
    chk(tx_ovf, 1'b1, "R6 flush keeps overflow flag");
    tx_ovf_clr = 1;
    step();
    clear_strobes();
    chk(tx_ovf, 1'b0, "R4 clear strobe drops flag");

    // R4 set beats clear in same cycle
    for (int i = 0; i < 32; i++) begin
      rx_push = 1; rx_wdata = 8'(i);
      step();
      clear_strobes();
    end
    rx_push = 1; rx_ovf_clr = 1;
    step();
    clear_strobes();
    chk(rx_ovf, 1'b1, "R4 set wins over clear");
    rx_ovf_clr = 1;
    step();
    clear_strobes();
    chk(rx_ovf, 1'b0, "R4 rx clear");

    // R6 flush with push in same cycle; other queue untouched
    rx_flush = 1; rx_push = 1; rx_wdata = 8'h55;
    step();
    clear_strobes();
    chk(level_word[11:6], 0, "R6 flush discards same-cycle push");
    chk(rx_head, 8'h00, "R6 flushed head reads zero");
    rx_push = 1; rx_wdata = 8'h11;
    step();
    rx_wdata = 8'h22;
    step();
    clear_strobes();
    tx_push = 1; tx_wdata = 8'h77;
    step();
    clear_strobes();
    tx_flush = 1;
    step();
    clear_strobes();
    chk(level_word, {6'd2, 6'd0}, "R6 tx flush leaves rx");

    // R9 push plus pop mid-fill
    rx_push = 1; rx_wdata = 8'h33; rx_pop = 1;
    step();
    clear_strobes();
    chk(level_word[11:6], 2, "R9 simultaneous push/pop level");
    chk(rx_head, 8'h22, "R9 head after simultaneous op");
    rx_pop = 1;
    step();
    clear_strobes();
    chk(rx_head, 8'h33, "R9 order preserved");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule